// File: doc/BRIEF.md
# Variable-Length Instruction Fetch with Shift Buffer

This block feeds a statically scheduled core whose instructions are compressed to a variable number of fixed-size quanta and packed back to back in program memory. Fixed-width memory words arrive one cycle after each request. The fetch unit cuts one instruction per cycle out of that bit stream and aligns it to the most significant end of a registered output word. Each instruction's length is found from a small template field at its top. The lower quanta of the output that the instruction does not use are cleared, so a later expansion stage sees nothing of the next instruction.

Buffered bits sit at the least significant end of a two-word holding register. The word arriving from memory is treated as a third, lowest slot of the same window. The current instruction is brought to the top by shifting the window left by a quantum count found from the number of valid quanta. A new word is requested only when at most one word's worth of quanta would remain held. This keeps the holding register within two words, and it keeps at least one full instruction present every cycle once streaming has begun.

A jump target is always word aligned. Asserting the jump input drops every held bit and the word still in flight, requests the target word in the same cycle and suppresses the output for one cycle. The first target instruction appears on the next cycle, so no fetch stall cycle is added.

Top module: `vlf_fetch`

## Requirements
- R1: While reset is low, `instr_vld` and `mem_req` are 0. In the first cycle after reset release, word address 0 is requested. The first instruction is valid at the second rising edge after that request.
- R2: An instruction's length in quanta is its top 2 bits (the template value) plus 1, with a 32-bit quantum, so lengths run from 1 to 4 quanta. `instr_out` carries the instruction's quanta from bit 127 downward, and every lower quantum reads zero.
- R3: Instructions appear in program order. Within a word, the first quantum sits at bits 127:96. An instruction may continue from the low end of one word into the top of the next word.
- R4: Consecutive requests go to consecutive word addresses, except for a jump request. Read data is taken one cycle after its request.
- R5: No word is requested while more than four quanta would remain held after the current issue. During such cycles `mem_stall` is 1 and `mem_req` is 0, and stalls do occur when runs of one-quantum instructions are fetched.
- R6: Once the first instruction has been output after reset or a jump, a valid instruction is output on every cycle until the next jump, whatever the mix of lengths.
- R7: When `jmp_valid` is 1, the target word is requested in that same cycle. `instr_vld` is 0 at the following edge, and the instruction that starts the target word is output at the edge after that.
- R8: The held bit count never exceeds two words, that is, eight quanta.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_req | output | 1 | Read request to program memory |
| mem_addr | output | 16 | Word address of the request |
| mem_rdata | input | 128 | Word read, valid one cycle after `mem_req` |
| mem_stall | output | 1 | Fetch held back because the buffer lacks room |
| jmp_valid | input | 1 | Taken control transfer |
| jmp_target | input | 16 | Word address of the jump target |
| instr_out | output | 128 | Aligned instruction, unused quanta zero |
| instr_vld | output | 1 | `instr_out` holds a new instruction |

## Verification
A wrong fill count or shift amount pulls the wrong bits to the top of the window, so the very next output instruction differs from the expected one, and every later output stays misaligned. A request rule that is too eager overruns the holding register within a few cycles of a run of short instructions. A rule that is too timid starves the issue logic and shows up as a missing valid on the next cycle. Jump handling faults appear within two edges as a leaked stale instruction, a missing bubble, or a wrong first target instruction.

// File: rtl/vlf_pkg.sv
package vlf_pkg;
  // Reason a word is requested this cycle
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_SEQ  = 2'd1,
    REQ_JUMP = 2'd2
  } req_kind_e;
endpackage

// File: rtl/vlf_align.sv
// Pulls the current instruction to the top of the three-word window.
module vlf_align #(
  parameter int WORD_W  = 128,
  parameter int QUANT_W = 32,
  parameter int TPL_W   = 2,
  parameter int CNT_W   = 4
) (
  input  logic [3*WORD_W-1:0] win,
  input  logic [CNT_W-1:0]    avail,
  output logic [WORD_W-1:0]   head,
  output logic [CNT_W-1:0]    head_len,
  output logic                head_ok
);
  localparam int NQ    = WORD_W / QUANT_W;
  localparam int WIN_Q = 3 * NQ;
  localparam int WIN_W = 3 * WORD_W;

  logic [WIN_W-1:0] shifted;

  // quanta to shift left so the oldest valid quantum reaches the top
  function automatic logic [CNT_W-1:0] shift_quanta(input logic [CNT_W-1:0] av);
    return CNT_W'(WIN_Q) - av;
  endfunction

  // instruction length in quanta from its template field
  function automatic logic [CNT_W-1:0] len_of(input logic [TPL_W-1:0] t);
    return CNT_W'(t) + 1'b1;
  endfunction

  always_comb begin
    shifted  = win << (shift_quanta(avail) * QUANT_W);
    head     = shifted[WIN_W-1 -: WORD_W];
    head_len = len_of(head[WORD_W-1 -: TPL_W]);
    head_ok  = (avail != '0) && (avail >= head_len);
  end
endmodule

// File: rtl/vlf_ctrl.sv
// Request sequencing: next word address, jump redirect, room check.
module vlf_ctrl
  import vlf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4,
  parameter int NQ     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jmp_valid,
  input  logic [ADDR_W-1:0] jmp_target,
  input  logic [CNT_W-1:0]  remain,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_stall,
  output logic              rd_live,
  output req_kind_e         req_kind
);
  logic              run_q;
  logic              pend_q;
  logic [ADDR_W-1:0] pc_q;

  // a whole word may land next cycle only if at most one word stays held
  function automatic logic room_for_word(input logic [CNT_W-1:0] r);
    return r <= CNT_W'(NQ);
  endfunction

  always_comb begin
    if (!run_q)                    req_kind = REQ_NONE;
    else if (jmp_valid)            req_kind = REQ_JUMP;
    else if (room_for_word(remain)) req_kind = REQ_SEQ;
    else                           req_kind = REQ_NONE;
  end

  assign mem_req   = (req_kind != REQ_NONE);
  assign mem_addr  = (req_kind == REQ_JUMP) ? jmp_target : pc_q;
  assign mem_stall = run_q && !mem_req;
  assign rd_live   = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      pc_q   <= '0;
    end else begin
      run_q  <= 1'b1;
      pend_q <= mem_req;
      if (mem_req) pc_q <= mem_addr + 1'b1;
    end
  end

  // R4
  seq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> (req_kind != REQ_SEQ || mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  // R1
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (req_kind == REQ_JUMP || (mem_req && mem_addr == '0)));
endmodule

// File: rtl/vlf_fetch.sv
// Variable-length fetch: two-word holding register plus incoming word slot.
module vlf_fetch
  import vlf_pkg::*;
#(
  parameter int WORD_W  = 128,
  parameter int QUANT_W = 32,
  parameter int TPL_W   = 2,
  parameter int ADDR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_stall,
  input  logic              jmp_valid,
  input  logic [ADDR_W-1:0] jmp_target,
  output logic [WORD_W-1:0] instr_out,
  output logic              instr_vld
);
  localparam int NQ    = WORD_W / QUANT_W;
  localparam int CNT_W = $clog2(3 * NQ + 1);
  localparam int BUF_W = 2 * WORD_W;
  localparam int WIN_W = 3 * WORD_W;

  logic [BUF_W-1:0]  buf_q;
  logic [CNT_W-1:0]  fill_q;
  logic [CNT_W-1:0]  avail;
  logic [CNT_W-1:0]  remain;
  logic [CNT_W-1:0]  head_len;
  logic [WIN_W-1:0]  win;
  logic [WORD_W-1:0] head;
  logic [WORD_W-1:0] instr_q;
  logic              vld_q;
  logic              head_ok;
  logic              issue;
  logic              rd_live;
  req_kind_e         req_kind;

  // ones over the top n quanta of a word
  function automatic logic [WORD_W-1:0] keep_mask(input logic [CNT_W-1:0] n);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < NQ; i++)
      if (CNT_W'(i) < n) m[WORD_W-1-i*QUANT_W -: QUANT_W] = '1;
    return m;
  endfunction

  always_comb begin
    avail = rd_live ? fill_q + CNT_W'(NQ) : fill_q;
    win   = rd_live ? {buf_q, mem_rdata} : {{WORD_W{1'b0}}, buf_q};
  end

  vlf_align #(
    .WORD_W (WORD_W),
    .QUANT_W(QUANT_W),
    .TPL_W  (TPL_W),
    .CNT_W  (CNT_W)
  ) u_align (
    .win     (win),
    .avail   (avail),
    .head    (head),
    .head_len(head_len),
    .head_ok (head_ok)
  );

  assign issue  = head_ok && !jmp_valid;
  assign remain = issue ? avail - head_len : avail;

  vlf_ctrl #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .NQ    (NQ)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .jmp_valid (jmp_valid),
    .jmp_target(jmp_target),
    .remain    (remain),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_stall (mem_stall),
    .rd_live   (rd_live),
    .req_kind  (req_kind)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= '0;
      fill_q  <= '0;
      instr_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      buf_q  <= win[BUF_W-1:0];
      fill_q <= jmp_valid ? '0 : remain;
      vld_q  <= issue;
      if (issue) instr_q <= head & keep_mask(head_len);
    end
  end

  assign instr_out = instr_q;
  assign instr_vld = vld_q;

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= CNT_W'(2 * NQ));

  // R5
  word_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_live |-> fill_q <= CNT_W'(NQ));

  // R7
  jump_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_valid |=> (!instr_vld && fill_q == '0));

  // R2
  out_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_vld |-> ((instr_out & ~keep_mask(CNT_W'(instr_out[WORD_W-1 -: TPL_W]) + 1'b1)) == '0));

  // R6
  steady_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld && !jmp_valid) |=> instr_vld);
endmodule

// File: tb/vlf_fetch_tb.sv
module vlf_fetch_tb;
  localparam int W = 128;
  localparam int NWORDS = 64;
  localparam int NQT = 256;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          jmp_valid = 1'b0;
  logic [AW-1:0] jmp_target = '0;
  logic [W-1:0]  mem_rdata = '0;
  logic          mem_req, mem_stall, instr_vld;
  logic [AW-1:0] mem_addr;
  logic [W-1:0]  instr_out;

  always #5 clk = ~clk;

  vlf_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_stall(mem_stall), .jmp_valid(jmp_valid),
    .jmp_target(jmp_target), .instr_out(instr_out), .instr_vld(instr_vld)
  );

  logic [31:0] qarr [NQT];
  logic [W-1:0] mem [NWORDS];
  int istart [NQT];
  int ilen [NQT];
  int ninst = 0;
  logic [W-1:0] expq [$];
  int n_chk = 0, n_err = 0, pops = 0, stall_cyc = 0;
  bit cont_armed = 0, done = 0, prev_req = 0;
  logic [AW-1:0] prev_addr = '0;

  // memory model: one-cycle read latency
  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[5:0]];

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int seg_len(int s, int k);
    case (s)
      0: return ((k * 7 + k / 2) % 4) + 1;
      1: return 1;
      2: return 4;
      3: return (k % 2 == 0) ? 4 : 1;
      default: return (k % 3) + 2;
    endcase
  endfunction

  task automatic build();
    int ends [5] = '{64, 96, 160, 224, 256};
    int pos = 0;
    for (int s = 0; s < 5; s++) begin
      int k = 0;
      while (pos < ends[s]) begin
        int L = seg_len(s, k);
        if (pos + L > ends[s]) L = 1;
        istart[ninst] = pos;
        ilen[ninst] = L;
        for (int j = 0; j < L; j++)
          qarr[pos + j] = (j == 0) ? {2'(L - 1), 6'(s), 8'(k), 16'(ninst)}
                                   : {8'(j), 8'(s), 16'(ninst ^ 'h5a5a)};
        pos += L;
        ninst++;
        k++;
      end
    end
    for (int w = 0; w < NWORDS; w++)
      mem[w] = {qarr[4*w], qarr[4*w+1], qarr[4*w+2], qarr[4*w+3]};
  endtask

  function automatic logic [W-1:0] expected(int idx);
    logic [W-1:0] e = '0;
    for (int j = 0; j < ilen[idx]; j++) e[W-1-32*j -: 32] = qarr[istart[idx] + j];
    return e;
  endfunction

  // driver side of the scoreboard: queue every instruction from a word on
  task automatic load_from(int word);
    expq.delete();
    for (int i = 0; i < ninst; i++)
      if (istart[i] >= 4 * word) expq.push_back(expected(i));
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [W-1:0] e;
      chk(!(mem_stall && mem_req), "R5 stall with request", W'(mem_req), 0);
      if (prev_req && mem_req && !jmp_valid)
        chk(mem_addr == AW'(prev_addr + 1'b1), "R4 sequential address", W'(mem_addr), W'(prev_addr + 1'b1));
      prev_req = mem_req;
      prev_addr = mem_addr;
      if (mem_stall) stall_cyc++;
      if (cont_armed) chk(instr_vld, "R6 issue every cycle", W'(instr_vld), 1);
      if (instr_vld) begin
        cont_armed = 1;
        if (expq.size() == 0) chk(0, "R3 unexpected instruction", instr_out, 0);
        else begin
          e = expq.pop_front();
          chk(instr_out === e, "R3 order/content, R2 alignment", instr_out, e);
          pops++;
        end
      end
    end
  end

  task automatic wait_pops(int n);
    int start = pops;
    int t = 0;
    while (pops - start < n && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 5000) chk(0, "watchdog R6", W'(pops - start), W'(n));
  endtask

  task automatic do_jump(int word);
    @(negedge clk); #1;
    jmp_valid = 1'b1;
    jmp_target = AW'(word);
    load_from(word);
    cont_armed = 0;
    prev_req = 0;
    #1 chk(mem_req && mem_addr == AW'(word), "R7 target requested", W'(mem_addr), W'(word));
    @(posedge clk); #1 jmp_valid = 1'b0;
    @(negedge clk); #1 chk(!instr_vld, "R7 bubble after jump", W'(instr_vld), 0);
    @(negedge clk); #1 chk(instr_vld, "R7 target issued next", W'(instr_vld), 1);
  endtask

  initial begin
    build();
    load_from(0);
    repeat (3) @(negedge clk);
    chk(!instr_vld && !mem_req, "R1 quiet in reset", W'({instr_vld, mem_req}), 0);
    #1 rst_n = 1'b1;
    @(negedge clk); #1 chk(mem_req && mem_addr == '0, "R1 first fetch at 0", W'(mem_addr), 0);
    @(negedge clk); #1 chk(!instr_vld, "R1 no output before data", W'(instr_vld), 0);
    @(negedge clk); #1 chk(instr_vld, "R1 first instruction", W'(instr_vld), 1);
    wait_pops(38);
    do_jump(24);
    wait_pops(8);
    do_jump(40);
    begin
      int t = 0;
      while (expq.size() > 3 && t < 5000) begin
        @(negedge clk);
        t++;
      end
      if (t >= 5000) chk(0, "watchdog R3", W'(expq.size()), 3);
    end
    do_jump(0);
    wait_pops(20);
    chk(stall_cyc > 0, "R5 stall seen on short instructions", W'(stall_cyc), 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule